// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This block gathers the seven event sources of an I2C controller into three 16-bit registers: a pending-event status word, an enable mask and an encoded vector. The bus engine reports each event as a one-cycle pulse on its own bit of `evt_pulse`. The event stays latched as pending until software removes it. Events that are pending and enabled drive a single interrupt line. An interrupt handler reads the vector register again and again. Each read returns the code of the most urgent enabled event and retires that event. The sequence ends when the vector reads zero.

Two ways retire a pending event. A vector read removes the event it reports. A write of ones to the status word removes the access-ready and stop-detected events. The status word also shows two live levels from the bus engine: bus busy and receive shift register full. The register port is a plain single-cycle read/write strobe with combinational read data. No data stream passes through the block, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `i2c_evt_unit`

## Requirements
- R1: After reset the mask and every pending bit are 0. `irq` is low, and the mask, status and vector registers all read 0 while both live inputs are low.
- R2: A pulse on `evt_pulse[i]` sets pending bit i whatever the mask holds. Pending bits appear in the status register (offset 0x08) at these positions: arbitration lost bit 0, no-acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop detected bit 5, addressed-as-slave bit 6. `evt_pulse` uses the same bit numbering.
- R3: The mask register sits at offset 0x08 minus 4, which is 0x04. Its bits 6..0 are written and read back, and each bit enables the source with the same index. Bits 15..7 read 0.
- R4: `irq` is high exactly when at least one pending bit has its mask bit set. A masked pending event never raises `irq`.
- R5: A read at offset 0x28 returns the vector code of the enabled pending event with the lowest code. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7. The read returns 0 when no enabled event is pending.
- R6: A vector read that returns a nonzero code clears only the pending bit of that source. A vector read returning 0 changes nothing, and masked pending bits survive it.
- R7: A write to the status offset with bit 2 or bit 5 set clears the access-ready or stop-detected pending bit. Ones written to status bits 0, 1, 3, 4 and 6 have no effect.
- R8: An event pulse that arrives in the same cycle as a clear of its own pending bit leaves the bit set. This holds for clears by a vector read and for clears by a status write.
- R9: Status bit 12 follows `bus_busy` and bit 11 follows `rx_shift_full` as live levels. Writes to the status offset do not change them.
- R10: Reads at any offset other than 0x04, 0x08 and 0x28 return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| evt_pulse | input | 7 | One-cycle event pulses from the bus engine |
| bus_busy | input | 1 | Live bus-busy level |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a new event that lands in the exact cycle its own pending bit is being retired, by either a vector read or a status write. The stimulus has to place the pulse and the clearing access on the same clock edge. The driver therefore takes an event argument alongside every register access and asserts both together. A later read then shows whether the event survived. Masked sources that are pending while a vector read removes an enabled neighbour are built the same way: several pulses go out in one cycle under a partial mask.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  localparam int unsigned NSRC = 7;
  localparam int unsigned VCW  = 3;

  typedef enum logic [VCW-1:0] {
    VEC_NONE      = 3'd0,
    VEC_ARB_LOST  = 3'd1,
    VEC_NO_ACK    = 3'd2,
    VEC_ACC_RDY   = 3'd3,
    VEC_RX_RDY    = 3'd4,
    VEC_TX_RDY    = 3'd5,
    VEC_STOP_DET  = 3'd6,
    VEC_AS_SLAVE  = 3'd7
  } vec_code_e;

  localparam int unsigned SRC_ACC_RDY  = 2;
  localparam int unsigned SRC_STOP_DET = 5;

  localparam int unsigned STAT_RSF_BIT = 11;
  localparam int unsigned STAT_BB_BIT  = 12;

  localparam logic [NSRC-1:0] W1C_BITS =
    NSRC'((1 << SRC_ACC_RDY) | (1 << SRC_STOP_DET));

endpackage

// File: rtl/i2c_evt_latch.sv
module i2c_evt_latch #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign pend_o[i] = q;
  end

endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [N-1:0]  onehot_o,
  output logic [CW-1:0] code_o
);

  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;

  always_comb begin
    found_o = 1'b0;
    idx     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx     = IW'(i);
      end
    end
  end

  assign onehot_o = found_o ? (N'(1) << idx) : '0;
  assign code_o   = found_o ? (CW'(idx) + CW'(1)) : '0;

endmodule

// File: rtl/i2c_evt_mask.sv
module i2c_evt_mask #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

endmodule

// File: rtl/i2c_evt_unit.sv
module i2c_evt_unit
  import i2c_evt_pkg::*;
#(
  parameter int unsigned   DW       = 16,
  parameter int unsigned   AW       = 6,
  parameter logic [AW-1:0] OFS_MASK = 6'h04,
  parameter logic [AW-1:0] OFS_STAT = 6'h08,
  parameter logic [AW-1:0] OFS_VEC  = 6'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NSRC-1:0] evt_pulse,
  input  logic          bus_busy,
  input  logic          rx_shift_full,
  output logic          irq
);

  logic sel_mask, sel_stat, sel_vec;
  logic [NSRC-1:0] pend_q, mask_q, enabled, vec_hit, clr_vec, clr_w1c;
  logic            vec_found;
  logic [VCW-1:0]  vec_code;
  logic [DW-1:0]   stat_word;
  logic            wdata_unused;

  assign sel_mask = (reg_addr == OFS_MASK);
  assign sel_stat = (reg_addr == OFS_STAT);
  assign sel_vec  = (reg_addr == OFS_VEC);

  i2c_evt_mask #(.N(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_wr & sel_mask),
    .wdata_i (reg_wdata[NSRC-1:0]),
    .mask_o  (mask_q)
  );

  assign enabled = pend_q & mask_q;

  i2c_evt_prio #(.N(NSRC), .CW(VCW)) u_prio (
    .req_i    (enabled),
    .found_o  (vec_found),
    .onehot_o (vec_hit),
    .code_o   (vec_code)
  );

  assign clr_vec = (reg_rd & sel_vec & vec_found) ? vec_hit : '0;
  assign clr_w1c = (reg_wr & sel_stat) ? (reg_wdata[NSRC-1:0] & W1C_BITS) : '0;

  i2c_evt_latch #(.N(NSRC)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (clr_vec | clr_w1c),
    .pend_o (pend_q)
  );

  always_comb begin
    stat_word               = '0;
    stat_word[NSRC-1:0]     = pend_q;
    stat_word[STAT_RSF_BIT] = rx_shift_full;
    stat_word[STAT_BB_BIT]  = bus_busy;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_mask)      reg_rdata = DW'(mask_q);
      else if (sel_stat) reg_rdata = stat_word;
      else if (sel_vec)  reg_rdata = DW'(vec_code);
    end
  end

  assign irq = |enabled;

  assign wdata_unused = ^reg_wdata[DW-1:NSRC];

endmodule

// File: rtl/i2c_evt_chk.sv
module i2c_evt_chk #(
  parameter int unsigned   N        = 7,
  parameter int unsigned   DW       = 16,
  parameter int unsigned   AW       = 6,
  parameter logic [AW-1:0] OFS_MASK = 6'h04,
  parameter logic [AW-1:0] OFS_STAT = 6'h08,
  parameter logic [AW-1:0] OFS_VEC  = 6'h28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [N-1:0]  evt_pulse,
  input logic          bus_busy,
  input logic          irq,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask
);

  logic          rd_vec, rd_stat, rd_other;
  logic [N-1:0]  rep_bit, below;

  assign rd_vec   = reg_rd && (reg_addr == OFS_VEC);
  assign rd_stat  = reg_rd && (reg_addr == OFS_STAT);
  assign rd_other = reg_rd && (reg_addr != OFS_VEC) && (reg_addr != OFS_STAT)
                           && (reg_addr != OFS_MASK);

  always_comb begin
    rep_bit = '0;
    below   = '0;
    for (int i = 0; i < N; i++) begin
      if (reg_rdata == DW'(i + 1)) rep_bit[i] = 1'b1;
      if (DW'(i + 1) < reg_rdata)  below[i]   = 1'b1;
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend == '0 && mask == '0)); // R1

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((pend & $past(evt_pulse)) == $past(evt_pulse))); // R2

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_MASK) |=> (mask == $past(reg_wdata[N-1:0]))); // R3

  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec |-> (irq == (reg_rdata != '0))); // R4

  AST_VEC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && reg_rdata != '0) |-> ((pend & mask & below) == '0)); // R5

  AST_VEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && (|rep_bit) && ((evt_pulse & rep_bit) == '0))
      |=> ((pend & $past(rep_bit)) == '0)); // R6

  AST_BB_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (reg_rdata[12] == bus_busy)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |-> (reg_rdata == '0)); // R10

endmodule

bind i2c_evt_unit i2c_evt_chk #(
  .N(i2c_evt_pkg::NSRC), .DW(DW), .AW(AW),
  .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT), .OFS_VEC(OFS_VEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .evt_pulse (evt_pulse),
  .bus_busy  (bus_busy),
  .irq       (irq),
  .pend      (pend_q),
  .mask      (mask_q)
);

// File: tb/i2c_evt_unit_test.sv
module i2c_evt_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        bus_busy = 1'b0, rx_shift_full = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  i2c_evt_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .rx_shift_full(rx_shift_full), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [6:0]  m_pend = '0, m_mask = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [15:0] vec_of(logic [6:0] p, logic [6:0] m);
    for (int i = 0; i < 7; i++)
      if (p[i] & m[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  function automatic logic [15:0] model_read(logic [5:0] a);
    case (a)
      6'h04:   return {9'd0, m_mask};
      6'h08:   return {3'd0, bus_busy, rx_shift_full, 4'd0, m_pend};
      6'h28:   return vec_of(m_pend, m_mask);
      default: return 16'd0;
    endcase
  endfunction

  task automatic report(logic [15:0] got, logic [15:0] exp, string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // driver: one register access plus optional event pulses in the same cycle
  task automatic bus_op(logic wr, logic rd, logic [5:0] a, logic [15:0] wd,
                        logic [6:0] ev, string tag);
    logic [6:0]  clr;
    logic [15:0] v;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; evt_pulse = ev;
    if (rd) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    @(posedge clk);
    clr = '0;
    if (wr && a == 6'h08) clr = wd[6:0] & 7'b0100100;
    if (rd && a == 6'h28) begin
      v = vec_of(m_pend, m_mask);
      if (v != 0) clr[v-1] = 1'b1;
    end
    m_pend = (m_pend & ~clr) | ev;
    if (wr && a == 6'h04) m_mask = wd[6:0];
    #1;
    reg_wr = 0; reg_rd = 0; evt_pulse = '0;
  endtask

  task automatic rd(logic [5:0] a, string tag);
    bus_op(0, 1, a, 16'd0, 7'd0, tag);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d, string tag);
    bus_op(1, 0, a, d, 7'd0, tag);
  endtask

  task automatic ev(logic [6:0] e);
    bus_op(0, 0, 6'h00, 16'd0, e, "EV");
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk); #1;
    report({15'd0, irq}, {15'd0, |(m_pend & m_mask)}, tag);
  endtask

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    #1;
    if (reg_rd) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL monitor: got 0x%04h expected none", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report(reg_rdata, e, t);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h04, "R1"); rd(6'h08, "R1"); rd(6'h28, "R1"); chk_irq("R1");

    // R2 all events latch while masked; R4 no irq; R5 vector 0; R6 no change
    ev(7'h7F);
    rd(6'h08, "R2"); chk_irq("R4"); rd(6'h28, "R5"); rd(6'h08, "R6");

    // R3 mask write/readback, upper bits zero
    wr(6'h04, 16'hFFFF, "R3"); rd(6'h04, "R3"); chk_irq("R4");

    // R5 drain by priority, then 0
    for (int i = 0; i < 8; i++) rd(6'h28, "R5");
    rd(6'h08, "R6"); chk_irq("R4");

    // R6 partial mask: masked source survives vector reads
    wr(6'h04, 16'h0022, "R3");
    ev(7'h23); chk_irq("R4");
    for (int i = 0; i < 3; i++) rd(6'h28, "R6");
    rd(6'h08, "R6"); chk_irq("R4");

    // R7 write-one-to-clear only on bits 2 and 5
    ev(7'h2C);
    rd(6'h08, "R7"); wr(6'h08, 16'hFFFF, "R7"); rd(6'h08, "R7");

    // R8 event coincident with its own clear
    bus_op(1, 0, 6'h08, 16'h0004, 7'h04, "R8");
    rd(6'h08, "R8");
    wr(6'h04, 16'h0004, "R8");
    bus_op(0, 1, 6'h28, 16'd0, 7'h04, "R8");
    rd(6'h28, "R8"); rd(6'h28, "R6"); chk_irq("R4");

    // R9 live levels
    @(negedge clk); bus_busy = 1; rx_shift_full = 1;
    rd(6'h08, "R9"); wr(6'h08, 16'hFFFF, "R9"); rd(6'h08, "R9");
    @(negedge clk); bus_busy = 0; rx_shift_full = 0;
    rd(6'h08, "R9");

    // R10 unmapped offsets
    rd(6'h00, "R10"); rd(6'h3E, "R10");
    wr(6'h10, 16'hFFFF, "R10"); rd(6'h04, "R10");

    // R4 enabling mask raises irq for an already pending source
    wr(6'h04, 16'h0000, "R4"); ev(7'h40); chk_irq("R4");
    wr(6'h04, 16'h0040, "R4"); chk_irq("R4");
    rd(6'h28, "R5"); chk_irq("R4");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule